// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Arithmetic Unit

A byte-wide register-bus peripheral that computes signed 16x16 products, signed-by-unsigned quotients with remainders, and running sums of products in a 40-bit accumulator. The host writes a control byte to select the operation. It then writes the two 16-bit operands a byte at a time. The write of the high byte of the second operand launches the computation, and the result is registered on that same clock edge.

The accumulator doubles as the result register. Multiply and divide overwrite it. Multiply-accumulate adds into it and raises a sticky overflow flag when the 40-bit signed sum wraps. The host reads the result back as five bytes. No stall or handshake is needed: a read in the bus cycle after the launching write already returns the new value.

Write map: 0 control, 1 operand A low, 2 operand A high, 3 operand B low, 4 operand B high (launch). Read map: addresses 0 to 4 return result bytes 0 to 4.

Top module: `mul_div_acc`

## Requirements
- R1: After reset, all five result bytes read 0, overflow is 0, both operands are 0 and the operation is multiply.
- R2: Control bits 1:0 select the operation: 0 multiply, 1 divide, 2 or 3 multiply-accumulate. A control write with bit 1 set clears the accumulator and the overflow flag. Control bits 7:2 are ignored.
- R3: Only a write to address 4 starts an operation. Writes to addresses 0 to 3 without a clear, and idle cycles, leave the result unchanged.
- R4: Multiply stores the signed product of A and B, sign-extended to 40 bits.
- R5: Divide treats A as signed and B as unsigned. It places the quotient, truncated toward zero, in bits 15:0 and the remainder, carrying the dividend's sign, in bits 31:16. Bits 39:32 are 0.
- R6: Divide by zero yields quotient 0 and remainder A, so the result is {8'h00, A, 16'h0000}.
- R7: Multiply-accumulate adds the sign-extended signed product to the accumulator, modulo 2^40. Code 3 behaves like code 2.
- R8: Overflow sets when a multiply-accumulate addition overflows as a 40-bit signed sum. It stays set until reset or a clearing control write. Multiply and divide leave it unchanged.
- R9: Read address k (0 to 4) returns result bits 8k+7:8k, and addresses 5 to 15 read 0. The result of a launching write is visible on the first read after that write's clock edge.
- R10: Operand bytes hold their values between operations, so a launch reuses any byte that was not rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| ovf_o | output | 1 | Sticky accumulate overflow flag |

## Verification
Multiply is tried with small positive operands, with mixed signs, and with both extreme corners (-32768 squared and 32767 times -32768); these separate signed from unsigned products and show whether sign extension reaches bit 39. Divide is tried with positive and negative dividends and with a divisor of 65535; these tell signed division from unsigned and truncation from flooring. A zero divisor is also applied. Accumulation is run with mixed-sign terms and a negative wrap. It is also run as 512 additions of 2^30, where the 511th sum must not flag and the 512th must flag, which pins down the overflow boundary exactly.

// File: rtl/mda_pkg.sv
package mda_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_A_LO = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_A_HI = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_B_LO = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_B_HI = 4'd4;

  typedef enum logic [1:0] {
    MODE_MUL     = 2'd0,
    MODE_DIV     = 2'd1,
    MODE_MAC     = 2'd2,
    MODE_MAC_ALT = 2'd3
  } mode_e;
endpackage

// File: rtl/mda_regs.sv
module mda_regs
  import mda_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned OP_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_e             mode_o,
  output logic [OP_W-1:0]   op_a_o,
  output logic [OP_W-1:0]   op_b_o,
  output logic [OP_W-1:0]   op_b_eff_o,
  output logic              start_o,
  output logic              clr_o
);
  mode_e           mode_q;
  logic [OP_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_MUL;
      a_q    <= '0;
      b_q    <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADR_CTRL: mode_q               <= mode_e'(wdata_i[1:0]);
        ADR_A_LO: a_q[DATA_W-1:0]      <= wdata_i;
        ADR_A_HI: a_q[OP_W-1:DATA_W]   <= wdata_i;
        ADR_B_LO: b_q[DATA_W-1:0]      <= wdata_i;
        ADR_B_HI: b_q[OP_W-1:DATA_W]   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign start_o    = wr_en_i && (addr_i == ADR_B_HI);
  assign clr_o      = wr_en_i && (addr_i == ADR_CTRL) && wdata_i[1];
  // operand B as seen by the launching write: new high byte, held low byte
  assign op_b_eff_o = {wdata_i, b_q[DATA_W-1:0]};
  assign mode_o     = mode_q;
  assign op_a_o     = a_q;
  assign op_b_o     = b_q;
endmodule

// File: rtl/mda_divider.sv
module mda_divider #(
  parameter int unsigned OP_W = 16
) (
  input  logic [OP_W-1:0] dividend_i,  // signed
  input  logic [OP_W-1:0] divisor_i,   // unsigned
  output logic [OP_W-1:0] quot_o,
  output logic [OP_W-1:0] rem_o
);
  logic            neg;
  logic [OP_W-1:0] mag, q_u, r_u;
  logic [OP_W:0]   part [OP_W+1];

  assign neg     = dividend_i[OP_W-1];
  assign mag     = neg ? (~dividend_i + OP_W'(1)) : dividend_i;
  assign part[0] = '0;

  // restoring division, one stage per quotient bit, MSB first
  for (genvar i = 0; i < OP_W; i++) begin : g_stage
    logic [OP_W:0] trial;
    logic          ge;
    assign trial           = {part[i][OP_W-1:0], mag[OP_W-1-i]};
    assign ge              = trial >= {1'b0, divisor_i};
    assign part[i+1]       = ge ? (trial - {1'b0, divisor_i}) : trial;
    assign q_u[OP_W-1-i]   = ge;
  end

  assign r_u = part[OP_W][OP_W-1:0];

  always_comb begin
    if (divisor_i == '0) begin
      quot_o = '0;
      rem_o  = dividend_i;
    end else begin
      quot_o = neg ? (~q_u + OP_W'(1)) : q_u;
      rem_o  = neg ? (~r_u + OP_W'(1)) : r_u;
    end
  end
endmodule

// File: rtl/mda_datapath.sv
module mda_datapath #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] mul_o,
  output logic [ACC_W-1:0] div_o,
  output logic [ACC_W-1:0] mac_o,
  output logic             mac_ovf_o
);
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic        [OP_W-1:0]   quot, rem;

  assign prod  = $signed(op_a_i) * $signed(op_b_i);
  assign mul_o = {{EXT_W{prod[PROD_W-1]}}, prod};

  mda_divider #(.OP_W(OP_W)) u_div (
    .dividend_i (op_a_i),
    .divisor_i  (op_b_i),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  assign div_o = {{EXT_W{1'b0}}, rem, quot};

  assign mac_o     = acc_i + mul_o;
  // signed wrap: addends agree in sign, sum does not
  assign mac_ovf_o = (acc_i[ACC_W-1] == mul_o[ACC_W-1]) &&
                     (mac_o[ACC_W-1] != acc_i[ACC_W-1]);
endmodule

// File: rtl/mul_div_acc.sv
module mul_div_acc
  import mda_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_o
);
  localparam int unsigned OP_W      = 2 * DATA_W;
  localparam int unsigned RES_BYTES = ACC_W / DATA_W;
  localparam int unsigned IDX_W     = $clog2(RES_BYTES);

  mode_e            mode;
  logic [OP_W-1:0]  op_a, op_b_q, op_b_eff;
  logic             start, clr;
  logic [ACC_W-1:0] acc_q, mul_res, div_res, mac_res;
  logic             mac_ovf, ovf_q;

  mda_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mode_o     (mode),
    .op_a_o     (op_a),
    .op_b_o     (op_b_q),
    .op_b_eff_o (op_b_eff),
    .start_o    (start),
    .clr_o      (clr)
  );

  mda_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
    .op_a_i    (op_a),
    .op_b_i    (op_b_eff),
    .acc_i     (acc_q),
    .mul_o     (mul_res),
    .div_o     (div_res),
    .mac_o     (mac_res),
    .mac_ovf_o (mac_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (start) begin
      unique case (mode)
        MODE_MUL: acc_q <= mul_res;
        MODE_DIV: acc_q <= div_res;
        default: begin
          acc_q <= mac_res;
          ovf_q <= ovf_q | mac_ovf;
        end
      endcase
    end
  end

  logic [DATA_W-1:0] res_byte [RES_BYTES];
  for (genvar g = 0; g < RES_BYTES; g++) begin : g_rd
    assign res_byte[g] = acc_q[g*DATA_W +: DATA_W];
  end

  assign rdata_o = (int'(addr_i) < RES_BYTES) ? res_byte[addr_i[IDX_W-1:0]] : '0;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/mul_div_acc_chk.sv
module mul_div_acc_chk
  import mda_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 40,
  localparam int unsigned OP_W  = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [3:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ovf_o,
  input logic [ACC_W-1:0]  acc_i,
  input logic [OP_W-1:0]   op_a_i,
  input logic [OP_W-1:0]   op_b_i,
  input logic [1:0]        mode_i
);
  logic launch, clear;
  assign launch = wr_en_i && (addr_i == ADR_B_HI);
  assign clear  = wr_en_i && (addr_i == ADR_CTRL) && wdata_i[1];

  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (acc_i == '0) && !ovf_o);

  a_r3_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch || clear) |=> $stable(acc_i));

  a_r6_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && mode_i == MODE_DIV && wdata_i == '0 && op_b_i[DATA_W-1:0] == '0)
    |=> acc_i == {{(ACC_W-2*OP_W){1'b0}}, $past(op_a_i), {OP_W{1'b0}}});

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clear) |=> ovf_o);

  a_r8_no_flag_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && !mode_i[1]) |=> ovf_o == $past(ovf_o));
endmodule

bind mul_div_acc mul_div_acc_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ovf_o   (ovf_o),
  .acc_i   (acc_q),
  .op_a_i  (op_a),
  .op_b_i  (op_b_q),
  .mode_i  (mode)
);

// File: tb/mul_div_acc_tb.sv
module mul_div_acc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mul_div_acc u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ovf_o   (ovf_o)
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic read_res(output logic [39:0] r);
    logic [7:0] b;
    for (int k = 0; k < 5; k++) begin
      rd(4'(k), b);
      r[k*8 +: 8] = b;
    end
  endtask

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    wr(4'd1, a[7:0]); wr(4'd2, a[15:8]);
    wr(4'd3, b[7:0]); wr(4'd4, b[15:8]);
  endtask

  function automatic logic [39:0] e_mul(input logic [15:0] a, input logic [15:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return p[39:0];
  endfunction

  function automatic logic [39:0] e_div(input logic [15:0] a, input logic [15:0] b);
    int q, r, dv;
    if (b == 16'h0) return {8'h00, a, 16'h0000};
    dv = int'({16'h0000, b});
    q = int'($signed(a)) / dv;
    r = int'($signed(a)) % dv;
    return {8'h00, r[15:0], q[15:0]};
  endfunction

  task automatic t_reset();
    logic [39:0] r;
    logic [7:0]  b;
    read_res(r);
    chk("R1 result after reset", r, 40'h0);
    chk("R1 overflow after reset", {39'h0, ovf_o}, 40'h0);
    // operands zero, mode multiply: launch with B high byte 0 gives 0
    wr(4'd4, 8'h00);
    read_res(r);
    chk("R1 default mode and operands", r, 40'h0);
    rd(4'd9, b);
    chk("R9 unmapped read", {32'h0, b}, 40'h0);
  endtask

  task automatic t_mul();
    logic [39:0] r;
    logic [15:0] av [4] = '{16'd3, 16'hFFFE, 16'h8000, 16'h7FFF};
    logic [15:0] bv [4] = '{16'd5, 16'd7, 16'h8000, 16'h8000};
    wr(4'd0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      load(av[i], bv[i]);
      read_res(r);
      chk("R4 signed multiply", r, e_mul(av[i], bv[i]));
    end
    chk("R8 multiply keeps flag clear", {39'h0, ovf_o}, 40'h0);
  endtask

  task automatic t_readback();
    logic [39:0] r;
    logic [7:0]  b;
    wr(4'd0, 8'h00);
    load(16'h1234, 16'h0100);   // product 0x00123400
    for (int k = 0; k < 5; k++) begin
      rd(4'(k), b);
      chk("R9 byte lane", {32'h0, b}, {32'h0, e_mul(16'h1234, 16'h0100) >> (8*k)} & 40'hFF);
    end
    for (int k = 5; k < 16; k++) begin
      rd(4'(k), b);
      chk("R9 reads above byte 4 are zero", {32'h0, b}, 40'h0);
    end
    read_res(r);
    chk("R9 assembled result", r, 40'h0000123400);
  endtask

  task automatic t_div();
    logic [39:0] r;
    logic [15:0] av [5] = '{16'd100, 16'hFF9C, 16'h8000, 16'd5, 16'hFFFB};
    logic [15:0] bv [5] = '{16'd7, 16'd7, 16'd1, 16'hFFFF, 16'hFFFF};
    wr(4'd0, 8'h01);
    for (int i = 0; i < 5; i++) begin
      load(av[i], bv[i]);
      read_res(r);
      chk("R5 divide", r, e_div(av[i], bv[i]));
    end
  endtask

  task automatic t_div0();
    logic [39:0] r;
    wr(4'd0, 8'h01);
    load(16'h1234, 16'h0000);
    read_res(r);
    chk("R6 divide by zero", r, 40'h0012340000);
    load(16'h8001, 16'h0000);
    read_res(r);
    chk("R6 divide by zero negative", r, 40'h0080010000);
  endtask

  task automatic t_no_start();
    logic [39:0] r;
    wr(4'd0, 8'h00);
    load(16'd10, 16'd3);
    read_res(r);
    chk("R10 baseline", r, 40'd30);
    wr(4'd1, 8'h55); wr(4'd2, 8'h66); wr(4'd3, 8'h77);
    wr(4'd0, 8'hFD);            // mode 1, bit 1 clear, upper bits ignored
    repeat (3) @(negedge clk_i);
    read_res(r);
    chk("R3 non-launch writes keep result", r, 40'd30);
    // mode now divide: A=0x6655, B={0x00,0x77}
    wr(4'd4, 8'h00);
    read_res(r);
    chk("R2 upper control bits ignored", r, e_div(16'h6655, 16'h0077));
    // R10: only A low and B rewritten, A high retained
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h02);
    wr(4'd3, 8'h04); wr(4'd4, 8'h00);
    read_res(r);
    chk("R10 operand byte retained", r, e_mul(16'h6602, 16'h0004));
  endtask

  task automatic t_mac();
    logic [39:0] r, exp;
    wr(4'd0, 8'h02);
    read_res(r);
    chk("R2 MAC select clears", r, 40'h0);
    load(16'd3, 16'd4);
    load(16'hFFFE, 16'd5);
    load(16'd100, 16'd100);
    exp = 40'd12 - 40'd10 + 40'd10000;
    read_res(r);
    chk("R7 accumulate mixed signs", r, exp);
    wr(4'd0, 8'h03);
    load(16'hFFFF, 16'd1);
    read_res(r);
    chk("R7 code 3 accumulates and wraps", r, 40'hFFFFFFFFFF);
    load(16'd2, 16'd1);
    read_res(r);
    chk("R7 wrap through zero", r, 40'd1);
    chk("R8 no overflow on small sums", {39'h0, ovf_o}, 40'h0);
  endtask

  task automatic t_ovf();
    logic [39:0] r;
    wr(4'd0, 8'h02);
    load(16'h8000, 16'h8000);    // +2^30
    for (int i = 1; i < 511; i++) wr(4'd4, 8'h80);
    read_res(r);
    chk("R8 511 terms no flag value", r, 40'd511 << 30);
    chk("R8 511 terms no flag", {39'h0, ovf_o}, 40'h0);
    wr(4'd4, 8'h80);
    read_res(r);
    chk("R8 512th term wraps", r, 40'h8000000000);
    chk("R8 512th term flags", {39'h0, ovf_o}, 40'h1);
    wr(4'd4, 8'h80);
    chk("R8 flag sticky", {39'h0, ovf_o}, 40'h1);
    wr(4'd0, 8'h00);
    load(16'd3, 16'd5);
    read_res(r);
    chk("R8 multiply after overflow", r, 40'd15);
    chk("R8 flag kept by multiply", {39'h0, ovf_o}, 40'h1);
    wr(4'd0, 8'h01);
    load(16'd9, 16'd2);
    chk("R8 flag kept by divide", {39'h0, ovf_o}, 40'h1);
    wr(4'd0, 8'h02);
    chk("R2 clear drops flag", {39'h0, ovf_o}, 40'h0);
    read_res(r);
    chk("R2 clear zeroes result", r, 40'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mul();
    t_readback();
    t_div();
    t_div0();
    t_no_start();
    t_mac();
    t_ovf();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule